// File: doc/BRIEF.md
# Prescaled Free-Running Timer

This block is a 16-bit up-counter that advances from the bus clock through a divider whose ratio is chosen by a two-bit field in a control register. Three capture channels each take a snapshot of the counter on a strobe. When the counter steps from its top value back to zero, an overflow flag is set. The flag drives an interrupt request whenever the matching enable bit is also set.

Software reaches the block through a byte-wide register bus. The divider ratio is locked once the block leaves an early configuration window: any write to the control register after the first 64 bus cycles following reset keeps the old ratio bits and updates only the remaining bits. The counter bytes are read straight from the running counter with no holding latch, so both bytes must be read within one prescale period.

Top module: `ptmr_timer`

## Requirements
- R1: Control register (address 0x8) bits [1:0] select the counter step period in bus cycles: 00 gives 1, 01 gives 4, 10 gives 8, 11 gives 16.
- R2: Bits [1:0] of the control register take the written value only on clock edges 0 to 63 after reset release. On any later write they keep their value, while bits [7:2] still take the written data.
- R3: The 16-bit counter rises by one at the end of each prescale period and wraps from 0xFFFF to 0x0000. Its high byte reads at address 0x0 and its low byte at address 0x1.
- R4: The wrap from 0xFFFF to 0x0000 sets the overflow flag, which is bit 7 of the flag register (address 0x9).
- R5: A high strobe on capture channel i (0 to 2) during a clock edge stores the counter value held before that edge. The stored high byte reads at address 0x2+2i and the low byte at 0x3+2i.
- R6: The interrupt output is high exactly while the overflow flag and control bit 7 (the overflow enable) are both set.
- R7: Writing the flag register clears the overflow flag when data bit 7 is 1 and leaves it unchanged when data bit 7 is 0.
- R8: Reset clears the counter, the three capture registers, the control register, the flag register and the auxiliary register, which leaves a step period of 1.
- R9: Read data appears on the cycle after the edge that samples a read. Flag bits [6:0] read as 0, and addresses 0xB to 0xF read as 0.
- R10: The auxiliary register at address 0xA keeps and returns any written byte.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cap_stb | input | 3 | Capture strobes, one per channel |
| bus_addr | input | 4 | Register byte address |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Registered read data |
| ovf_irq | output | 1 | Overflow interrupt request |

## Verification
The assertions assume that the prescale code reaching the divider changes only through a register write. They also assume that strobes and bus controls are stable at each rising edge, so every sampled strobe is a separate capture request. The bench drives all inputs on falling edges and counts rising edges from reset release itself. Each expected count, capture value and lock-window outcome is then a closed-form expression in that edge index and the chosen divide ratio. The bench sweeps all four prescale codes, puts captures on every channel, and makes control writes on both sides of the lock boundary.

// File: rtl/ptmr_pkg.sv
package ptmr_pkg;

    localparam int BYTE_W = 8;

    // Register byte addresses (decoded by the read mux and write logic).
    localparam int ADR_CNT_HI  = 0;
    localparam int ADR_CNT_LO  = 1;
    localparam int ADR_CAP_BAS = 2;
    localparam int ADR_CTRL    = 8;
    localparam int ADR_FLAG    = 9;
    localparam int ADR_AUX     = 10;

    // Control register field positions.
    localparam int CTRL_OVF_EN = 7;
    localparam int FLAG_OVF    = 7;

    typedef struct packed {
        logic [BYTE_W-1:0] ctrl;
        logic              tof;
        logic [BYTE_W-1:0] aux;
        logic [BYTE_W-1:0] rdata;
    } regs_t;

    // Divide ratio minus one for a two-bit prescale code.
    function automatic int unsigned ratio_m1(input logic [1:0] code);
        int unsigned r;
        r = (code == 2'b00) ? 1 : (1 << (int'(code) + 1));
        return r - 1;
    endfunction

endpackage

// File: rtl/ptmr_prescaler.sv
module ptmr_prescaler
    import ptmr_pkg::*;
#(
    parameter int LOCK_CYCLES = 64,
    parameter int MAX_RATIO   = 16
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [1:0] code_i,
    output logic       tick_o,
    output logic       win_open_o
);
    localparam int AGE_W = $clog2(LOCK_CYCLES + 1);
    localparam int DIV_W = $clog2(MAX_RATIO);

    typedef struct packed {
        logic [AGE_W-1:0] age;
        logic [DIV_W-1:0] div;
    } pre_t;

    pre_t st_d, st_q;
    logic [DIV_W-1:0] limit;
    logic tick;

    always_comb begin
        st_d  = st_q;
        limit = DIV_W'(ratio_m1(code_i));
        tick  = 1'b0;
        if (st_q.age != AGE_W'(LOCK_CYCLES)) begin
            st_d.age = st_q.age + 1'b1;
        end
        // >= keeps the divider safe if the ratio shrinks mid-period.
        if (st_q.div >= limit) begin
            tick     = 1'b1;
            st_d.div = '0;
        end else begin
            st_d.div = st_q.div + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign tick_o     = tick;
    assign win_open_o = (st_q.age < AGE_W'(LOCK_CYCLES));

    // With a ratio above one, two ticks never come back to back.
    p_tick_space_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (tick_o && code_i != 2'b00) ##1 $stable(code_i) |-> !tick_o);

    // Once closed, the configuration window stays closed until reset.
    p_win_closed_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !win_open_o |=> !win_open_o);

endmodule

// File: rtl/ptmr_counter.sv
module ptmr_counter #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick_i,
    output logic [CNT_W-1:0] cnt_o,
    output logic             wrap_o
);
    logic [CNT_W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (tick_i) cnt_d = cnt_q + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign cnt_o  = cnt_q;
    assign wrap_o = tick_i && (cnt_q == '1);

    p_cnt_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
        tick_i |=> cnt_o == CNT_W'($past(cnt_o) + 1'b1));

    p_cnt_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !tick_i |=> $stable(cnt_o));

endmodule

// File: rtl/ptmr_capture.sv
module ptmr_capture #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             stb_i,
    input  logic [CNT_W-1:0] cnt_i,
    output logic [CNT_W-1:0] cap_o
);
    logic [CNT_W-1:0] cap_d, cap_q;

    always_comb begin
        cap_d = cap_q;
        if (stb_i) cap_d = cnt_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cap_q <= '0;
        else        cap_q <= cap_d;
    end

    assign cap_o = cap_q;

    p_cap_take_r5: assert property (@(posedge clk) disable iff (!rst_n)
        stb_i |=> cap_o == $past(cnt_i));

    p_cap_keep_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !stb_i |=> $stable(cap_o));

endmodule

// File: rtl/ptmr_timer.sv
module ptmr_timer
    import ptmr_pkg::*;
#(
    parameter int CNT_W       = 16,
    parameter int N_CAP       = 3,
    parameter int LOCK_CYCLES = 64,
    parameter int MAX_RATIO   = 16,
    parameter int ADDR_W      = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [N_CAP-1:0]  cap_stb,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [7:0]        bus_wdata,
    output logic [7:0]        bus_rdata,
    output logic              ovf_irq
);
    localparam logic [ADDR_W-1:0] A_HI   = ADDR_W'(ADR_CNT_HI);
    localparam logic [ADDR_W-1:0] A_LO   = ADDR_W'(ADR_CNT_LO);
    localparam logic [ADDR_W-1:0] A_CTRL = ADDR_W'(ADR_CTRL);
    localparam logic [ADDR_W-1:0] A_FLAG = ADDR_W'(ADR_FLAG);
    localparam logic [ADDR_W-1:0] A_AUX  = ADDR_W'(ADR_AUX);

    regs_t r_d, r_q;
    logic             tick, win_open, wrap;
    logic [CNT_W-1:0] cnt;
    logic [CNT_W-1:0] cap [N_CAP];
    logic [7:0]       rd_byte;

    ptmr_prescaler #(
        .LOCK_CYCLES (LOCK_CYCLES),
        .MAX_RATIO   (MAX_RATIO)
    ) u_pre (
        .clk        (clk),
        .rst_n      (rst_n),
        .code_i     (r_q.ctrl[1:0]),
        .tick_o     (tick),
        .win_open_o (win_open)
    );

    ptmr_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk    (clk),
        .rst_n  (rst_n),
        .tick_i (tick),
        .cnt_o  (cnt),
        .wrap_o (wrap)
    );

    for (genvar g = 0; g < N_CAP; g++) begin : g_cap
        ptmr_capture #(.CNT_W(CNT_W)) u_cap (
            .clk   (clk),
            .rst_n (rst_n),
            .stb_i (cap_stb[g]),
            .cnt_i (cnt),
            .cap_o (cap[g])
        );
    end

    // Read multiplexer: live counter, capture pairs, control and flags.
    always_comb begin
        rd_byte = '0;
        if (bus_addr == A_HI) rd_byte = cnt[CNT_W-1 -: 8];
        if (bus_addr == A_LO) rd_byte = cnt[7:0];
        for (int i = 0; i < N_CAP; i++) begin
            if (bus_addr == ADDR_W'(ADR_CAP_BAS + 2 * i))     rd_byte = cap[i][CNT_W-1 -: 8];
            if (bus_addr == ADDR_W'(ADR_CAP_BAS + 2 * i + 1)) rd_byte = cap[i][7:0];
        end
        if (bus_addr == A_CTRL) rd_byte = r_q.ctrl;
        if (bus_addr == A_FLAG) rd_byte = {r_q.tof, 7'b0};
        if (bus_addr == A_AUX)  rd_byte = r_q.aux;
    end

    always_comb begin
        r_d = r_q;
        if (bus_rd) r_d.rdata = rd_byte;
        if (bus_wr) begin
            if (bus_addr == A_CTRL) begin
                r_d.ctrl = bus_wdata;
                if (!win_open) r_d.ctrl[1:0] = r_q.ctrl[1:0];
            end
            if (bus_addr == A_FLAG && bus_wdata[FLAG_OVF]) r_d.tof = 1'b0;
            if (bus_addr == A_AUX) r_d.aux = bus_wdata;
        end
        // A wrap in the same cycle as a clear wins.
        if (wrap) r_d.tof = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    assign bus_rdata = r_q.rdata;
    assign ovf_irq   = r_q.tof & r_q.ctrl[CTRL_OVF_EN];

    p_pre_lock_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !win_open |=> $stable(r_q.ctrl[1:0]));

    p_ovf_set_r4: assert property (@(posedge clk) disable iff (!rst_n)
        wrap |=> r_q.tof);

    p_ovf_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == A_FLAG && bus_wdata[FLAG_OVF] && !wrap) |=> !r_q.tof);

    p_ovf_keep_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.tof && !(bus_wr && bus_addr == A_FLAG && bus_wdata[FLAG_OVF])) |=> r_q.tof);

    p_irq_gate_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !r_q.ctrl[CTRL_OVF_EN] |-> !ovf_irq);

    p_rd_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_rd |=> $stable(bus_rdata));

endmodule

// File: tb/ptmr_timer_tb_top.sv
module ptmr_timer_tb_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [2:0] cap_stb = '0;
    logic [3:0] bus_addr = '0;
    logic       bus_wr = 1'b0;
    logic       bus_rd = 1'b0;
    logic [7:0] bus_wdata = '0;
    logic [7:0] bus_rdata;
    logic       ovf_irq;

    int n_tests = 0;
    int n_fail  = 0;
    int cyc;
    bit done = 1'b0;

    ptmr_timer dut_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .cap_stb   (cap_stb),
        .bus_addr  (bus_addr),
        .bus_wr    (bus_wr),
        .bus_rd    (bus_rd),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .ovf_irq   (ovf_irq)
    );

    always #5 clk = ~clk;

    // Rising-edge index since reset release, read at falling edges.
    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) cyc <= 0;
        else        cyc <= cyc + 1;
    end

    task automatic check(input string req, input int got, input int exp);
        n_tests++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: got 0x%0h expected 0x%0h (edge %0d)", req, got, exp, cyc);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic wait_to(input int e);
        while (cyc < e) @(negedge clk);
    endtask

    task automatic wr(input int a, input int d);
        bus_addr = 4'(a); bus_wdata = 8'(d); bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input int a, output int d, output int e);
        e = cyc;
        bus_addr = 4'(a); bus_rd = 1'b1;
        @(negedge clk);
        bus_rd = 1'b0;
        d = int'(bus_rdata);
    endtask

    task automatic strobe(input int mask, output int e);
        e = cyc;
        cap_stb = 3'(mask);
        @(negedge clk);
        cap_stb = '0;
    endtask

    // Counter value before edge e when the code was written at edge 0.
    function automatic int exp_cnt(input int e, input int r);
        if (e == 0) return 0;
        return (1 + (e - 1) / r) & 16'hFFFF;
    endfunction

    function automatic int ratio(input int code);
        return (code == 0) ? 1 : (1 << (code + 1));
    endfunction

    initial begin
        int d, e, ec;
        do_reset();
        // R8 reset state, counter read directly at edge 0.
        rd(1, d, e); check("R8 cnt lo", d, 0);
        rd(8, d, e); check("R8 ctrl", d, 0);
        rd(9, d, e); check("R8 flag", d, 0);
        rd(10, d, e); check("R8 aux", d, 0);
        for (int a = 2; a < 8; a++) begin
            rd(a, d, e); check("R8 capture", d, 0);
        end
        check("R8 irq", int'(ovf_irq), 0);
        for (int a = 11; a < 16; a++) begin
            rd(a, d, e); check("R9 unmapped", d, 0);
        end
        wr(10, 8'hA5);
        rd(10, d, e); check("R10 aux", d, 8'hA5);
        // R3 counter at ratio 1 and R9 direct byte reads.
        for (int k = 0; k < 4; k++) begin
            rd(1, d, e); check("R3 cnt lo", d, e & 8'hFF);
            rd(0, d, e); check("R3 cnt hi", d, (e >> 8) & 8'hFF);
        end
        // R5 each channel alone, then all together.
        for (int ch = 0; ch < 3; ch++) begin
            strobe(1 << ch, ec);
            rd(2 + 2 * ch, d, e); check("R5 cap hi", d, (ec >> 8) & 8'hFF);
            rd(3 + 2 * ch, d, e); check("R5 cap lo", d, ec & 8'hFF);
        end
        strobe(7, ec);
        for (int ch = 0; ch < 3; ch++) begin
            rd(3 + 2 * ch, d, e); check("R5 joint cap lo", d, ec & 8'hFF);
        end
        wr(8, 8'h80);
        // R2 after the window: ratio bits kept, enable bit updated.
        wait_to(70);
        wr(8, 8'h83);
        rd(8, d, e); check("R2 locked ctrl", d, 8'h80);
        rd(1, d, e); check("R2 ratio kept", d, e & 8'hFF);
        // R4 overflow around the wrap.
        wait_to(65530);
        rd(9, d, e); check("R4 flag before wrap", d, 0);
        check("R6 irq before wrap", int'(ovf_irq), 0);
        wait_to(65540);
        rd(9, d, e); check("R4 flag after wrap", d, 8'h80);
        check("R6 irq asserted", int'(ovf_irq), 1);
        rd(1, d, e); check("R3 wrapped lo", d, e & 8'hFF);
        rd(0, d, e); check("R3 wrapped hi", d, ((e & 16'hFFFF) >> 8) & 8'hFF);
        wr(9, 8'h7F);
        rd(9, d, e); check("R7 zero bit keeps flag", d, 8'h80);
        wr(8, 8'h00);
        check("R6 irq masked", int'(ovf_irq), 0);
        wr(8, 8'h80);
        check("R6 irq unmasked", int'(ovf_irq), 1);
        wr(9, 8'h80);
        rd(9, d, e); check("R7 flag cleared", d, 0);
        check("R6 irq after clear", int'(ovf_irq), 0);

        // R1 sweep over all codes with captures.
        for (int code = 0; code < 4; code++) begin
            int r;
            r = ratio(code);
            do_reset();
            wr(8, code);
            for (int k = 0; k < 12; k++) begin
                rd(1, d, e); check("R1 cnt lo", d, exp_cnt(e, r) & 8'hFF);
                rd(0, d, e); check("R1 cnt hi", d, (exp_cnt(e, r) >> 8) & 8'hFF);
                repeat (k) @(negedge clk);
                strobe(1 << (k % 3), ec);
                rd(3 + 2 * (k % 3), d, e); check("R5 cap lo scaled", d, exp_cnt(ec, r) & 8'hFF);
            end
            wait_to(100);
            wr(8, (code ^ 3) | 8'h04);
            rd(8, d, e); check("R2 late write", d, code | 8'h04);
            rd(1, d, e); check("R1 ratio after late write", d, exp_cnt(e, r) & 8'hFF);
        end

        // R2 window boundary.
        do_reset();
        wait_to(63);
        wr(8, 8'h02);
        rd(8, d, e); check("R2 edge 63 accepted", d, 8'h02);
        do_reset();
        wait_to(64);
        wr(8, 8'h03);
        rd(8, d, e); check("R2 edge 64 ignored", d, 8'h00);

        if (!done) begin
            done = 1'b1;
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        #1900000;
        if (!done) begin
            done = 1'b1;
            n_tests++;
            n_fail++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

endmodule